// File: doc/BRIEF.md
# Event Counter Bank

A bank of wide event counters for a processor core's performance monitor. Every cycle the core presents a packed event bus. Some fields on that bus are single bits. Others are small binary counts that say how many times something happened in that cycle.

Each counter has its own 8-bit selector. The selector picks one field, or a free-running cycle source. While counting is allowed, the counter adds that field's value every clock.

Counters are grouped in pairs. An odd-numbered counter can count the wrap-arounds of the even-numbered counter just below it, which joins the pair into one wider count. Each wrap-around also sets a sticky flag for that counter. Software reaches the controls, the selectors, the flags and the counter values through a small word-wide write port and a combinational read port.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every counter value, selector, the master enable, the enable mask and every wrap flag read as zero.
- R2: A counter advances only in a cycle when the master enable (bit 0 at address 0x00) and its own bit in the enable mask (address 0x01, bit i for counter i) are both set. Otherwise it holds its value.
- R3: Selectors 0x16, 0x17, 0x18 and 0x1B add the unsigned value of the 3-bit bus fields [24:22], [27:25], [30:28] and [36:34] respectively. The value is added as a count, not as a single increment.
- R4: Selector 0x19 adds the 2-bit beat count in bus bits [32:31]. The value 2 means a read beat and a write beat in the same cycle, so 2 is added.
- R5: Selectors 0x15, 0x1A and 0x1C add bus bit 21, bit 33 and bit 37 respectively.
- R6: Selectors 0x11 and 0x1D each add 1 in every enabled cycle, so they give identical counts.
- R7: An odd counter i with selector 0x1E adds 1 in each cycle where counter i-1 wraps past its maximum value. A disabled counter i-1 never wraps and never produces a chain step.
- R8: An even counter with selector 0x1E never changes except by a software write.
- R9: Any selector value not listed in R3 to R7 adds 0.
- R10: A counter addition that passes 0xFFFFFFFF keeps the low 32 bits and sets that counter's bit in the wrap-flag register (address 0x02, bit i). The bit is cleared only by writing 1 to it. Writing 0 leaves it unchanged, and a new wrap in the same cycle as a clear leaves it set.
- R11: A software write to a counter value (address 0x10+i) in a cycle when that counter would advance stores the written value, and the advance is dropped.
- R12: Selector i sits at address 0x08+i and reads back the 8 bits that were written. Counter i's value sits at address 0x10+i. `rd_data` follows `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bus | input | 40 | Packed per-cycle event fields |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| wrap_flags | output | 4 | Sticky wrap flag per counter |

## Verification
A counter picks up the event fields that are present before a clock edge at that same edge, so a value written or counted at edge N can be read back in the half cycle that follows. A counting session starts with a write of the master enable and ends with a write that clears it. Each expected count is therefore the number of patterned cycles for field events, and one more than that for cycle events, because the edge that clears the master enable still counts. Reads are queued only while counting is stopped. The monitor compares `rd_data` a quarter period after the falling edge on which the address was driven, well before the next rising edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int CNT_W    = 32;
    localparam int EVSEL_W  = 8;
    localparam int INC_W    = 3;
    localparam int EVBUS_W  = 40;
    localparam int ADDR_W   = 5;

    localparam int A_CTRL   = 'h00;
    localparam int A_ENMASK = 'h01;
    localparam int A_WRAP   = 'h02;
    localparam int A_SEL    = 'h08;
    localparam int A_VAL    = 'h10;

    typedef enum logic [EVSEL_W-1:0] {
        EV_CORE_CLK  = 8'h11,
        EV_L1_EVICT  = 8'h15,
        EV_L2_LOOKUP = 8'h16,
        EV_L2_FILL   = 8'h17,
        EV_L2_EVICT  = 8'h18,
        EV_BEATS     = 8'h19,
        EV_RAM_FAULT = 8'h1A,
        EV_SPEC      = 8'h1B,
        EV_TBASE_WR  = 8'h1C,
        EV_IFACE_CLK = 8'h1D,
        EV_LINK      = 8'h1E
    } ev_code_e;

    typedef struct packed {
        logic [INC_W-1:0] amount;
        logic             is_link;
    } ev_pick_t;

    function automatic ev_pick_t pick_event(logic [EVSEL_W-1:0] code,
                                            logic [EVBUS_W-1:0] bus);
        ev_pick_t p;
        p = '0;
        case (code)
            EV_CORE_CLK,
            EV_IFACE_CLK: p.amount = INC_W'(1);
            EV_L1_EVICT:  p.amount = INC_W'(bus[21]);
            EV_L2_LOOKUP: p.amount = bus[24:22];
            EV_L2_FILL:   p.amount = bus[27:25];
            EV_L2_EVICT:  p.amount = bus[30:28];
            EV_BEATS:     p.amount = INC_W'(bus[32:31]);
            EV_RAM_FAULT: p.amount = INC_W'(bus[33]);
            EV_SPEC:      p.amount = bus[36:34];
            EV_TBASE_WR:  p.amount = INC_W'(bus[37]);
            EV_LINK:      p.is_link = 1'b1;
            default:      p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pmc_event_decode.sv
module pmc_event_decode
    import pmc_pkg::*;
#(
    parameter bit IS_ODD = 1'b0
) (
    input  logic [EVSEL_W-1:0] sel,
    input  logic [EVBUS_W-1:0] ev_bus,
    input  logic               link_in,
    output logic [INC_W-1:0]   inc
);
    ev_pick_t pick;

    always_comb begin
        pick = pick_event(sel, ev_bus);
        inc  = pick.amount;
        if (pick.is_link) begin
            inc = IS_ODD ? INC_W'(link_in) : '0;
        end
    end

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [INC_W-1:0] inc,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_data,
    output logic [CNT_W-1:0] value,
    output logic             wrap
);
    logic [CNT_W:0] sum;

    always_comb begin
        sum  = {1'b0, value} + (CNT_W+1)'(inc);
        wrap = active && !sw_wr && sum[CNT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (sw_wr) begin
            value <= sw_data;
        end else if (active) begin
            value <= sum[CNT_W-1:0];
        end
    end

    // R2: a counter that is not allowed to count keeps its value
    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!active && !sw_wr) |=> $stable(value));

    // R11: a software write wins over a same-cycle advance
    p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> (value == $past(sw_data)));

endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [CNT_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]    cnt_vals,
    input  logic [NUM_CNT-1:0]               wraps,
    output logic                             glb_en,
    output logic [NUM_CNT-1:0]               en_mask,
    output logic [NUM_CNT-1:0][EVSEL_W-1:0]  sels,
    output logic [NUM_CNT-1:0]               val_wr,
    output logic [NUM_CNT-1:0]               flags,
    output logic [CNT_W-1:0]                 rd_data
);
    logic wr_ctrl, wr_mask, wr_wrap;
    logic [NUM_CNT-1:0] sel_wr;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        wr_mask = wr_en && (wr_addr == ADDR_W'(A_ENMASK));
        wr_wrap = wr_en && (wr_addr == ADDR_W'(A_WRAP));
        for (int i = 0; i < NUM_CNT; i++) begin
            sel_wr[i] = wr_en && (wr_addr == ADDR_W'(A_SEL + i));
            val_wr[i] = wr_en && (wr_addr == ADDR_W'(A_VAL + i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en  <= 1'b0;
            en_mask <= '0;
        end else begin
            if (wr_ctrl) glb_en  <= wr_data[0];
            if (wr_mask) en_mask <= wr_data[NUM_CNT-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                sels[g]  <= '0;
                flags[g] <= 1'b0;
            end else begin
                if (sel_wr[g]) sels[g] <= wr_data[EVSEL_W-1:0];
                if (wraps[g]) begin
                    flags[g] <= 1'b1;
                end else if (wr_wrap && wr_data[g]) begin
                    flags[g] <= 1'b0;
                end
            end
        end

        // R10: a wrap always leaves the flag set
        p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
            wraps[g] |=> flags[g]);

        // R10: only a written 1 clears the flag
        p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
            (flags[g] && !(wr_wrap && wr_data[g])) |=> flags[g]);
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_CTRL))   rd_data = CNT_W'(glb_en);
        if (rd_addr == ADDR_W'(A_ENMASK)) rd_data = CNT_W'(en_mask);
        if (rd_addr == ADDR_W'(A_WRAP))   rd_data = CNT_W'(flags);
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_addr == ADDR_W'(A_SEL + i)) rd_data = CNT_W'(sels[i]);
            if (rd_addr == ADDR_W'(A_VAL + i)) rd_data = cnt_vals[i];
        end
    end

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [EVBUS_W-1:0]   ev_bus,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [CNT_W-1:0]     rd_data,
    output logic [NUM_CNT-1:0]   wrap_flags
);
    logic                            glb_en;
    logic [NUM_CNT-1:0]              en_mask;
    logic [NUM_CNT-1:0][EVSEL_W-1:0] sels;
    logic [NUM_CNT-1:0]              val_wr;
    logic [NUM_CNT-1:0][CNT_W-1:0]   vals;
    logic [NUM_CNT-1:0]              wraps;
    logic [NUM_CNT-1:0]              links;
    logic [NUM_CNT-1:0]              active;
    logic [NUM_CNT-1:0][INC_W-1:0]   incs;

    pmc_regs #(.NUM_CNT(NUM_CNT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .cnt_vals (vals),
        .wraps    (wraps),
        .glb_en   (glb_en),
        .en_mask  (en_mask),
        .sels     (sels),
        .val_wr   (val_wr),
        .flags    (wrap_flags),
        .rd_data  (rd_data)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam bit ODD = (g % 2) == 1;

        if (ODD) begin : g_link
            assign links[g] = wraps[g-1];
        end else begin : g_nolink
            assign links[g] = 1'b0;
        end

        assign active[g] = glb_en && en_mask[g];

        pmc_event_decode #(.IS_ODD(ODD)) u_dec (
            .sel     (sels[g]),
            .ev_bus  (ev_bus),
            .link_in (links[g]),
            .inc     (incs[g])
        );

        pmc_counter u_cnt (
            .clk     (clk),
            .rst     (rst),
            .active  (active[g]),
            .inc     (incs[g]),
            .sw_wr   (val_wr[g]),
            .sw_data (wr_data),
            .value   (vals[g]),
            .wrap    (wraps[g])
        );

        if (ODD) begin : g_chk_odd
            // R7: a wrap of the lower counter steps a chained odd counter by one
            p_chain_step_r7: assert property (@(posedge clk) disable iff (rst)
                (sels[g] == EV_LINK && active[g] && !val_wr[g] && wraps[g-1])
                |=> (vals[g] == $past(vals[g]) + 1'b1));
        end else begin : g_chk_even
            // R8: an even counter on the chain selector never moves by itself
            p_even_link_r8: assert property (@(posedge clk) disable iff (rst)
                (sels[g] == EV_LINK && !val_wr[g]) |=> $stable(vals[g]));
        end
    end

endmodule

// File: tb/pmc_bank_test.sv
module pmc_bank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [39:0] ev_bus;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [4:0]  rd_addr;
    logic [31:0] rd_data;
    logic [3:0]  wrap_flags;

    typedef struct {
        logic [4:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pmc_bank uut (
        .clk        (clk),
        .rst        (rst),
        .ev_bus     (ev_bus),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wrap_flags (wrap_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare queued reads a quarter period after the falling edge
    always @(negedge clk) begin
        item_t it;
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (rd_data !== it.exp) begin
                errors++;
                $display("FAIL %s addr=%0h actual=%0h expected=%0h",
                         it.tag, it.addr, rd_data, it.exp);
            end
        end
    end

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        ev_bus  = '0;
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        q.push_back(it);
        @(posedge clk);
    endtask

    // enable, drive pattern for n cycles, disable: cycle sources add n+1
    task automatic session(input logic [39:0] p, input int n);
        reg_wr(5'h00, 32'd1);
        repeat (n) begin
            @(negedge clk);
            ev_bus = p;
        end
        reg_wr(5'h00, 32'd0);
    endtask

    function automatic logic [39:0] pat(input int l2, input int beats, input bit b21);
        logic [39:0] v;
        v = '0;
        v[24:22] = 3'(l2);
        v[32:31] = 2'(beats);
        v[21]    = b21;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [39:0] p;
        rst = 1'b1; ev_bus = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_rd(5'h00, 32'd0, "R1 master enable");
        expect_rd(5'h10, 32'd0, "R1 counter0");
        expect_rd(5'h13, 32'd0, "R1 counter3");
        expect_rd(5'h02, 32'd0, "R1 wrap flags");
        expect_rd(5'h09, 32'd0, "R1 selector1");

        // Setup for R3 R4 R5 R6
        reg_wr(5'h08, 32'h16);
        reg_wr(5'h09, 32'h19);
        reg_wr(5'h0A, 32'h15);
        reg_wr(5'h0B, 32'h1D);
        reg_wr(5'h01, 32'hF);
        expect_rd(5'h09, 32'h19, "R12 selector readback");
        expect_rd(5'h01, 32'hF, "R12 enable mask readback");

        p = pat(5, 2, 1'b1);
        p[33] = 1'b1;
        session(p, 3);
        expect_rd(5'h10, 32'd15, "R3 field count 5x3");
        expect_rd(5'h11, 32'd6,  "R4 both beats add 2");
        expect_rd(5'h12, 32'd3,  "R5 bit 21");
        expect_rd(5'h13, 32'd4,  "R6 cycle count n+1");

        session(pat(7, 1, 1'b0), 2);
        expect_rd(5'h10, 32'd29, "R3 field max value");
        expect_rd(5'h11, 32'd8,  "R4 single beat");
        expect_rd(5'h12, 32'd3,  "R5 bit clear adds 0");
        expect_rd(5'h13, 32'd7,  "R6 cycles second session");

        // R2 per-counter enable off
        reg_wr(5'h01, 32'hB);
        session(pat(0, 0, 1'b1), 2);
        expect_rd(5'h12, 32'd3,  "R2 masked counter holds");
        expect_rd(5'h13, 32'd10, "R2 unmasked counter runs");

        // R9 unsupported selector
        reg_wr(5'h08, 32'h40);
        session({40{1'b1}}, 2);
        expect_rd(5'h10, 32'd29, "R9 unsupported adds 0");
        expect_rd(5'h11, 32'd14, "R4 field value 3");
        expect_rd(5'h08, 32'h40, "R12 selector8 readback");

        // R2 master enable off: pattern present, nothing counts
        repeat (3) begin
            @(negedge clk);
            ev_bus = {40{1'b1}};
        end
        @(negedge clk);
        ev_bus = '0;
        expect_rd(5'h13, 32'd13, "R2 master off holds");

        // R7 R8 R10 chain and wrap
        reg_wr(5'h08, 32'h1D);
        reg_wr(5'h09, 32'h1E);
        reg_wr(5'h0A, 32'h1E);
        reg_wr(5'h10, 32'hFFFF_FFFE);
        reg_wr(5'h11, 32'd5);
        reg_wr(5'h12, 32'd9);
        reg_wr(5'h13, 32'd0);
        reg_wr(5'h01, 32'hF);
        session('0, 2);
        expect_rd(5'h10, 32'd1, "R10 wrap keeps low bits");
        expect_rd(5'h11, 32'd6, "R7 chain step on wrap");
        expect_rd(5'h12, 32'd9, "R8 even chain idle");
        expect_rd(5'h13, 32'd3, "R6 cycles during chain");
        expect_rd(5'h02, 32'h1, "R10 flag set");
        reg_wr(5'h02, 32'h0);
        expect_rd(5'h02, 32'h1, "R10 write 0 keeps flag");
        reg_wr(5'h02, 32'h1);
        expect_rd(5'h02, 32'h0, "R10 write 1 clears flag");

        // R7 disabled lower counter gives no chain step
        reg_wr(5'h10, 32'hFFFF_FFFF);
        reg_wr(5'h01, 32'h2);
        session('0, 1);
        expect_rd(5'h10, 32'hFFFF_FFFF, "R2 disabled lower holds");
        expect_rd(5'h11, 32'd6, "R7 no step when lower disabled");
        expect_rd(5'h02, 32'h0, "R7 no wrap flag");

        // R11 write wins over increment
        reg_wr(5'h10, 32'h10);
        reg_wr(5'h01, 32'hF);
        reg_wr(5'h00, 32'd1);
        reg_wr(5'h13, 32'd100);
        reg_wr(5'h00, 32'd0);
        expect_rd(5'h13, 32'd101, "R11 write wins then counts");
        expect_rd(5'h10, 32'h12, "R6 counter0 two cycles");

        // R6 both cycle selectors match
        reg_wr(5'h08, 32'h11);
        reg_wr(5'h10, 32'd0);
        reg_wr(5'h13, 32'd0);
        session('0, 4);
        expect_rd(5'h10, 32'd5, "R6 core cycle selector");
        expect_rd(5'h13, 32'd5, "R6 interface cycle selector");

        // R3 R5 other fields
        reg_wr(5'h08, 32'h17);
        reg_wr(5'h09, 32'h1B);
        reg_wr(5'h0A, 32'h1C);
        reg_wr(5'h0B, 32'h1A);
        for (int i = 0; i < 4; i++) reg_wr(5'(16 + i), 32'd0);
        p = '0;
        p[27:25] = 3'd6;
        p[36:34] = 3'd4;
        p[37]    = 1'b1;
        p[30:28] = 3'd7;
        session(p, 3);
        expect_rd(5'h10, 32'd18, "R3 field 27:25");
        expect_rd(5'h11, 32'd12, "R3 field 36:34");
        expect_rd(5'h12, 32'd3,  "R5 bit 37");
        expect_rd(5'h13, 32'd0,  "R5 bit 33 clear");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule